// File: doc/BRIEF.md
# Infrared Receive Run-Length Encoder

This block watches the demodulated output of an infrared receiver and turns the line into one-byte run-length codes. Each code holds the level of the run in its top bit and the run length in 10 microsecond ticks in the seven bits below. A prescaler makes the tick from the block clock. A run longer than the seven-bit field can hold is split into several codes of the same level. The codes go into a small FIFO that the host drains through a show-ahead read port.

The host can invert the receiver polarity, turn reception off, and let reception carry on while the transmitter is busy. A FIFO that fills up raises a sticky overrun flag, and the host clears it with a pulse. A line that stays idle keeps producing saturated space codes (0xFF). The host can take a run of these as the end of a burst.

Top module: `ir_rle_rx`

## Requirements
- R1: After reset the FIFO is empty, `data_avail` is 0 and `overrun` is 0.
- R2: Bit 7 of a code is the line level after optional inversion: 1 means space (line high), 0 means pulse (line low). Bits 6:0 hold the run length in ticks, from 1 to 127, and are never 0.
- R3: One tick lasts `CLK_PER_TICK` clock cycles, 240 by default, which is 10 us at 24 MHz. The line is sampled once per tick, and each sample adds one tick to the current run.
- R4: When the sampled level differs from the current run, the finished run is written as one code, and the new run starts with a count of 1.
- R5: When a run already holds 127 ticks and the next sample has the same level, a code with count 127 is written and a new code of the same level starts at 1. A line held at space therefore gives a series of 0xFF codes.
- R6: With `invert_en` high, the receiver input is inverted before encoding, so a low line is coded as space.
- R7: The FIFO holds 16 codes in order. `rd_data` shows the oldest code, `data_avail` is high exactly when the FIFO is not empty, and a read pulse removes one code.
- R8: A code that arrives while the FIFO is full, with no read in the same cycle, is dropped and sets `overrun`. Reads do not clear `overrun`. An `ovr_clr` pulse clears it, and a new overrun in the same cycle wins over the clear.
- R9: While `rx_disable` is high, no code is written, the partial run is discarded and the tick prescaler restarts.
- R10: While `tx_busy` is high and `txrx_allow` is low, reception is masked in the same way as R9. With `txrx_allow` high, `tx_busy` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (24 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated receiver line, asynchronous |
| invert_en | input | 1 | Invert receiver polarity |
| rx_disable | input | 1 | Stop reception and drop the partial run |
| tx_busy | input | 1 | Transmitter active |
| txrx_allow | input | 1 | Keep receiving while the transmitter is active |
| rd_en | input | 1 | Pop the oldest code |
| rd_data | output | 8 | Oldest code, shown ahead of the read |
| data_avail | output | 1 | FIFO not empty |
| ovr_clr | input | 1 | Clear the overrun flag |
| overrun | output | 1 | Sticky: a code was lost to a full FIFO |

## Verification
The hardest cases to reach are the exact run boundaries. A run must end on a chosen tick, which means the line changes have to line up with the prescaler phase, and the phase is hidden behind a two-stage synchronizer. The bench starts each pattern by releasing `rx_disable`, which restarts the prescaler at a known edge. It then moves the line half a tick after that point, and from there in whole ticks, so every segment covers an exact number of samples. That makes the 127-tick split, the repeated 0xFF idle codes, and the discarding of a run cut short by disable all show up as exact byte values. The overrun case uses twenty one-tick runs with no reads, which pushes codes into a full FIFO.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
   typedef enum logic {
      LVL_PULSE = 1'b0,
      LVL_SPACE = 1'b1
   } ir_level_e;

   localparam int unsigned DEF_CNT_W      = 7;
   localparam int unsigned DEF_FIFO_DEPTH = 16;
   localparam int unsigned DEF_TICK_CLKS  = 240;
endpackage

// File: rtl/ir_rle_tick.sv
module ir_rle_tick #(
   parameter int unsigned CLK_PER_TICK = ir_rle_pkg::DEF_TICK_CLKS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic tick
);
   localparam int unsigned PW = (CLK_PER_TICK > 2) ? $clog2(CLK_PER_TICK) : 1;
   localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

   generate
      if (CLK_PER_TICK < 2) begin : g_bad_period
         $error("CLK_PER_TICK must be at least 2");
      end
   endgenerate

   logic [PW-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (!active)
         pre_q <= '0;
      else if (pre_q == LAST)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end

   assign tick = active && (pre_q == LAST);

   // R3
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/ir_rle_runlen.sv
module ir_rle_runlen #(
   parameter int unsigned CNT_W = ir_rle_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic             lvl,
   output logic             push,
   output logic [CNT_W:0]   code
);
   import ir_rle_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("CNT_W must be at least 2");
      end
   endgenerate

   ir_level_e        cur_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= LVL_SPACE;
         cnt_q <= '0;
         push  <= 1'b0;
         code  <= '0;
      end else begin
         push <= 1'b0;
         if (!active) begin
            cnt_q <= '0;
         end else if (tick) begin
            if (cnt_q == '0) begin
               cur_q <= ir_level_e'(lvl);
               cnt_q <= CNT_ONE;
            end else if (lvl != cur_q) begin
               push  <= 1'b1;
               code  <= {cur_q, cnt_q};
               cur_q <= ir_level_e'(lvl);
               cnt_q <= CNT_ONE;
            end else if (cnt_q == CNT_MAX) begin
               push  <= 1'b1;
               code  <= {cur_q, CNT_MAX};
               cnt_q <= CNT_ONE;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R2
   code_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (code[CNT_W-1:0] != '0));
   // R9
   gated_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !push);
   // R5
   sat_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tick && cnt_q == CNT_MAX && lvl == cur_q) |=> (push && code[CNT_W-1:0] == CNT_MAX));
   // R4
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tick && cnt_q != '0 && lvl != cur_q) |=> (cnt_q == CNT_ONE && push));
endmodule

// File: rtl/ir_rle_fifo.sv
module ir_rle_fifo #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = ir_rle_pkg::DEF_FIFO_DEPTH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          not_empty,
   input  logic          ovr_clr,
   output logic          overrun
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr_q, rptr_q;
   logic [AW:0]   cnt_q;
   logic          full, empty, do_wr, do_rd;

   assign full    = (cnt_q == FULL_CNT);
   assign empty   = (cnt_q == '0);
   assign do_rd   = rd_en && !empty;
   assign do_wr   = wr_en && (!full || do_rd);
   assign rd_data = mem[rptr_q];
   assign not_empty = !empty;

   always_ff @(posedge clk) begin
      if (do_wr)
         mem[wptr_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         cnt_q   <= '0;
         overrun <= 1'b0;
      end else begin
         if (do_wr)
            wptr_q <= wptr_q + 1'b1;
         if (do_rd)
            rptr_q <= rptr_q + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         overrun <= (overrun && !ovr_clr) || (wr_en && !do_wr);
      end
   end

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);
   // R7
   drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && cnt_q == (AW+1)'(1)) |=> !not_empty);
   // R8
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en) |=> overrun);
   // R8
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !ovr_clr) |=> overrun);
endmodule

// File: rtl/ir_rle_rx.sv
module ir_rle_rx #(
   parameter int unsigned CLK_PER_TICK = ir_rle_pkg::DEF_TICK_CLKS,
   parameter int unsigned CNT_W        = ir_rle_pkg::DEF_CNT_W,
   parameter int unsigned FIFO_DEPTH   = ir_rle_pkg::DEF_FIFO_DEPTH,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ir_in,
   input  logic             invert_en,
   input  logic             rx_disable,
   input  logic             tx_busy,
   input  logic             txrx_allow,
   input  logic             rd_en,
   output logic [CNT_W:0]   rd_data,
   output logic             data_avail,
   input  logic             ovr_clr,
   output logic             overrun
);
   localparam int unsigned CODE_W = CNT_W + 1;

   logic line_sync, active, tick, push;
   logic [CODE_W-1:0] code;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line_sync = ir_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sync_q <= '1;
            else if (SYNC_STAGES == 1)
               sync_q[0] <= ir_in;
            else
               sync_q <= {sync_q[SYNC_STAGES-2:0], ir_in};
         end
         assign line_sync = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   assign active = !rx_disable && !(tx_busy && !txrx_allow);

   ir_rle_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .tick   (tick)
   );

   ir_rle_runlen #(.CNT_W(CNT_W)) u_runlen (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .tick   (tick),
      .lvl    (line_sync ^ invert_en),
      .push   (push),
      .code   (code)
   );

   ir_rle_fifo #(.DW(CODE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (push),
      .wr_data   (code),
      .rd_en     (rd_en),
      .rd_data   (rd_data),
      .not_empty (data_avail),
      .ovr_clr   (ovr_clr),
      .overrun   (overrun)
   );

   // R10
   tx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && !txrx_allow) |-> !tick);
endmodule

// File: tb/sim_ir_rle_rx.sv
module sim_ir_rle_rx;
   localparam int P = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ir_in = 1'b1, invert_en = 1'b0, rx_disable = 1'b1;
   logic tx_busy = 1'b0, txrx_allow = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
   logic [7:0] rd_data;
   logic data_avail, overrun;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic seg_lvl [32];
   int   seg_len [32];
   int   nseg;
   logic [7:0] exp_q [128];
   int   nexp;

   always #10 clk = ~clk;

   ir_rle_rx #(.CLK_PER_TICK(P)) u0 (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .invert_en(invert_en),
      .rx_disable(rx_disable), .tx_busy(tx_busy), .txrx_allow(txrx_allow),
      .rd_en(rd_en), .rd_data(rd_data), .data_avail(data_avail),
      .ovr_clr(ovr_clr), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   task automatic add_seg(input logic l, input int n);
      seg_lvl[nseg] = l;
      seg_len[nseg] = n;
      nseg++;
   endtask

   // Bench model: merge equal levels, split runs above 127 ticks.
   task automatic build_exp();
      int run;
      logic lv;
      nexp = 0;
      lv  = seg_lvl[0] ^ invert_en;
      run = 0;
      for (int i = 0; i < nseg; i++) begin
         if ((seg_lvl[i] ^ invert_en) != lv) begin
            exp_q[nexp] = {lv, 7'(run)};
            nexp++;
            lv  = seg_lvl[i] ^ invert_en;
            run = 0;
         end
         run += seg_len[i];
         while (run > 127) begin
            exp_q[nexp] = {lv, 7'd127};
            nexp++;
            run -= 127;
         end
      end
      exp_q[nexp] = {lv, 7'(run)};
      nexp++;
   endtask

   task automatic play();
      ir_in = seg_lvl[0];
      @(negedge clk) rx_disable = 1'b0;
      repeat (P/2) @(negedge clk);
      for (int i = 0; i < nseg; i++) begin
         ir_in = seg_lvl[i];
         repeat (seg_len[i] * P) @(negedge clk);
      end
      ir_in = ~seg_lvl[nseg-1];
      repeat (2 * P) @(negedge clk);
      rx_disable = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic pop_chk(input logic [7:0] e, input string req);
      chk(data_avail === 1'b1, {req, " avail"}, data_avail, 1);
      chk(rd_data === e, req, rd_data, e);
      rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
   endtask

   task automatic drain(input int n, input string req);
      for (int i = 0; i < n; i++) pop_chk(exp_q[i], req);
      chk(data_avail === 1'b0, {req, " empty after drain"}, data_avail, 0);
   endtask

   task automatic t_reset();
      // R1
      chk(data_avail === 1'b0, "R1 avail", data_avail, 0);
      chk(overrun === 1'b0, "R1 overrun", overrun, 0);
      rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
      chk(data_avail === 1'b0, "R1 pop on empty", data_avail, 0);
   endtask

   task automatic t_basic();
      // R2 R3 R4 R7: mixed lengths, pulses low, spaces high
      nseg = 0;
      add_seg(1'b0, 3); add_seg(1'b1, 5); add_seg(1'b0, 1);
      add_seg(1'b1, 12); add_seg(1'b0, 40);
      build_exp();
      chk(exp_q[0] == 8'h03, "R2 model pulse code", exp_q[0], 8'h03);
      play();
      drain(nexp, "R4 R2 R3 basic runs");
   endtask

   task automatic t_long();
      // R5: pulse of 130 ticks splits into 0x7F then 0x03; 300 space ticks -> FF FF AE
      nseg = 0;
      add_seg(1'b0, 130); add_seg(1'b1, 300); add_seg(1'b0, 127);
      build_exp();
      play();
      drain(nexp, "R5 split runs");
   endtask

   task automatic t_invert();
      // R6: low line reads as space
      invert_en = 1'b1;
      nseg = 0;
      add_seg(1'b0, 6); add_seg(1'b1, 2);
      build_exp();
      play();
      pop_chk(8'h86, "R6 inverted low as space");
      pop_chk(8'h02, "R6 inverted high as pulse");
      chk(data_avail === 1'b0, "R6 empty", data_avail, 0);
      invert_en = 1'b0;
   endtask

   task automatic t_disable();
      // R9: partial run dropped across a disable
      ir_in = 1'b0;
      @(negedge clk) rx_disable = 1'b0;
      repeat (P/2 + 5*P) @(negedge clk);
      rx_disable = 1'b1;
      repeat (3) @(negedge clk);
      chk(data_avail === 1'b0, "R9 no code while disabled", data_avail, 0);
      nseg = 0;
      add_seg(1'b0, 3); add_seg(1'b1, 2);
      build_exp();
      play();
      drain(nexp, "R9 fresh run after disable");
   endtask

   task automatic t_txmask();
      // R10: masked with tx_busy, allowed with txrx_allow
      tx_busy = 1'b1;
      nseg = 0;
      add_seg(1'b0, 4); add_seg(1'b1, 4);
      build_exp();
      play();
      chk(data_avail === 1'b0, "R10 masked during tx", data_avail, 0);
      txrx_allow = 1'b1;
      play();
      drain(nexp, "R10 tx allowed");
      tx_busy = 1'b0;
      txrx_allow = 1'b0;
   endtask

   task automatic t_overrun();
      // R8: 20 codes into a 16-entry FIFO
      nseg = 0;
      for (int i = 0; i < 20; i++) add_seg(i[0] ? 1'b1 : 1'b0, 1);
      build_exp();
      play();
      chk(overrun === 1'b1, "R8 overrun set", overrun, 1);
      drain(16, "R8 first 16 kept");
      chk(overrun === 1'b1, "R8 overrun sticky over reads", overrun, 1);
      ovr_clr = 1'b1;
      @(negedge clk) ovr_clr = 1'b0;
      chk(overrun === 1'b0, "R8 overrun cleared", overrun, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_long();
      t_invert();
      t_disable();
      t_txmask();
      t_overrun();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule